// File: doc/BRIEF.md
# Single-Byte EPROM Program-and-Verify Sequencer

This block sits on the programmer side of a UV-erasable on-chip program store. Its job is to write one byte. It waits for a start command that carries a 12-bit location and an 8-bit value. It then drives the location and value onto the device pins and runs the write strobe under the high programming supply. Afterwards it reads the cell back and reports the outcome on a one-cycle completion strobe.

An erased cell reads all ones, and a write can only turn ones into zeros. For that reason the sequencer first reads the cell. If the requested value would need any bit raised from 0 to 1, the request is turned down and no strobe is issued.

All intervals come from parameters. The clock period and the oscillator period are given in nanoseconds. Each interval is rounded up to whole clock cycles. The address and data setup, the data hold and the read-access window are counted in target oscillator periods. The supply lead and lag times and the strobe width are absolute times.

Top module: `eprom_byte_prog`

## Requirements
- R1: While reset is held and after it is released, with no start, the block is idle. In that state `busy`, `pgm_en`, `vpp_en`, `verify_en`, `done`, `pass`, `fail` and `reject` are 0, `prog_n` is 1, and `prog_addr`/`prog_data` are 0.
- R2: A start seen at a clock edge while idle captures `addr_in`/`data_in`. `prog_addr`/`prog_data` then show the captured values until the next accepted start. `busy` stays 1 from the cycle after acceptance through the `done` cycle. A start while busy has no effect.
- R3: A pre-check comes first. `verify_en` is 1 for VFY cycles. At its last cycle the read-back is sampled. If any bit is 0 in the read-back and 1 in the request, the next cycle is the `done` cycle with `reject`=1. No enable, supply or strobe is issued in that case.
- R4: `pgm_en` rises SETUP cycles before `vpp_en` rises. SETUP is 48 oscillator periods in cycles.
- R5: `vpp_en` is 1 for VSU cycles before `prog_n` falls. It stays 1 for VHOLD cycles after `prog_n` rises.
- R6: `prog_n` is 0 for exactly PULSE cycles per accepted, non-rejected request. It is 0 only while `vpp_en` and `pgm_en` are both 1.
- R7: `pgm_en` stays 1, with address and data unchanged, for HOLD cycles (48 oscillator periods) after `vpp_en` falls.
- R8: After that, `pgm_en` falls and `verify_en` is 1 for VFY cycles. The read-back at the last of those cycles is compared with the request. The `done` cycle then shows `pass`=1 on a full match, or `fail`=1 otherwise.
- R9: `done` is 1 for exactly one cycle per accepted request. Exactly one of `pass`/`fail`/`reject` is 1 in that cycle, and none of them is 1 in any other cycle.
- R10: Every interval equals its time divided by the clock period, rounded up, with a minimum of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, honoured only when idle |
| addr_in | input | 12 | Location to write |
| data_in | input | 8 | Value to write |
| rd_data | input | 8 | Byte read back from the device data pins |
| prog_addr | output | 12 | Location driven to the device |
| prog_data | output | 8 | Value driven to the device while `pgm_en` is 1 |
| pgm_en | output | 1 | Programming enable; the data bus is driven while it is 1 |
| vpp_en | output | 1 | Enable for the external high-voltage supply |
| prog_n | output | 1 | Active-low write strobe |
| verify_en | output | 1 | Read-back enable; the data bus is released |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | With `done`: read-back matched |
| fail | output | 1 | With `done`: read-back differed |
| reject | output | 1 | With `done`: request needed a 0-to-1 change |

## Verification
The assertions check the ordering rules on every cycle. The strobe is never low without both the supply and the enable. The supply is never on without the enable. The enable stays up across the supply's fall. Read-back and drive never overlap. The location stays frozen while busy. Completion is a single cycle with exactly one result flag. A failed pre-check leads straight to a rejection.

Only the bench scenarios can show the exact lengths of every interval and the rounding-up of the absolute times. The same holds for the effect on the cell contents: that a rejected request leaves the cell untouched, and that a stuck bit turns into a fail. The scenarios also show that starts arriving mid-sequence or held across completion are handled as required.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SETUP,
    ST_VPP_ON,
    ST_PULSE,
    ST_VPP_HOLD,
    ST_RELEASE,
    ST_VERIFY,
    ST_DONE
  } prog_state_e;

  // Time in ns to whole clock cycles, rounded up, never below one.
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int osc_to_cycles(input int n_osc, input int osc_ns, input int clk_ns);
    return ns_to_cycles(n_osc * osc_ns, clk_ns);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eprom_prog_timer.sv
module eprom_prog_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/eprom_prog_guard.sv
module eprom_prog_guard #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rd_byte,
  input  logic [DATA_W-1:0] req_byte,
  output logic              illegal,
  output logic              match
);

  // A bit wanted high that already reads low cannot be written.
  assign illegal = |(req_byte & ~rd_byte);
  assign match   = (rd_byte == req_byte);

endmodule

// File: rtl/eprom_prog_fsm.sv
module eprom_prog_fsm
  import eprom_prog_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int VFY_CYC   = 1,
  parameter int SETUP_CYC = 1,
  parameter int VSU_CYC   = 1,
  parameter int PULSE_CYC = 1,
  parameter int VHOLD_CYC = 1,
  parameter int HOLD_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tmr_zero,
  input  logic             illegal,
  input  logic             match,
  output prog_state_e      state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             check_fail_evt,
  output logic             verify_evt,
  output logic             res_pass,
  output logic             res_fail,
  output logic             res_rej
);

  prog_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (start)    nxt = ST_CHECK;
      ST_CHECK:    if (tmr_zero) nxt = illegal ? ST_DONE : ST_SETUP;
      ST_SETUP:    if (tmr_zero) nxt = ST_VPP_ON;
      ST_VPP_ON:   if (tmr_zero) nxt = ST_PULSE;
      ST_PULSE:    if (tmr_zero) nxt = ST_VPP_HOLD;
      ST_VPP_HOLD: if (tmr_zero) nxt = ST_RELEASE;
      ST_RELEASE:  if (tmr_zero) nxt = ST_VERIFY;
      ST_VERIFY:   if (tmr_zero) nxt = ST_DONE;
      ST_DONE:                   nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_val = '0;
    unique case (nxt)
      ST_CHECK:    tmr_val = CNT_W'(VFY_CYC - 1);
      ST_SETUP:    tmr_val = CNT_W'(SETUP_CYC - 1);
      ST_VPP_ON:   tmr_val = CNT_W'(VSU_CYC - 1);
      ST_PULSE:    tmr_val = CNT_W'(PULSE_CYC - 1);
      ST_VPP_HOLD: tmr_val = CNT_W'(VHOLD_CYC - 1);
      ST_RELEASE:  tmr_val = CNT_W'(HOLD_CYC - 1);
      ST_VERIFY:   tmr_val = CNT_W'(VFY_CYC - 1);
      default:     tmr_val = '0;
    endcase
  end

  assign tmr_load       = (nxt != state);
  assign accept         = (state == ST_IDLE) && start;
  assign check_fail_evt = (state == ST_CHECK) && tmr_zero && illegal;
  assign verify_evt     = (state == ST_VERIFY) && tmr_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      res_pass <= 1'b0;
      res_fail <= 1'b0;
      res_rej  <= 1'b0;
    end else begin
      state <= nxt;
      if (check_fail_evt) begin
        res_pass <= 1'b0;
        res_fail <= 1'b0;
        res_rej  <= 1'b1;
      end else if (verify_evt) begin
        res_pass <= match;
        res_fail <= !match;
        res_rej  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/eprom_byte_prog.sv
module eprom_byte_prog
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 250,
  parameter int OSC_NS       = 250,
  parameter int EDGE_OSC     = 48,
  parameter int VPP_SETUP_NS = 10000,
  parameter int VPP_HOLD_NS  = 10000,
  parameter int PULSE_NS     = 50000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              pgm_en,
  output logic              vpp_en,
  output logic              prog_n,
  output logic              verify_en,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              reject
);

  localparam int SETUP_CYC = osc_to_cycles(EDGE_OSC, OSC_NS, CLK_NS);
  localparam int HOLD_CYC  = osc_to_cycles(EDGE_OSC, OSC_NS, CLK_NS);
  localparam int VFY_CYC   = osc_to_cycles(EDGE_OSC, OSC_NS, CLK_NS);
  localparam int VSU_CYC   = ns_to_cycles(VPP_SETUP_NS, CLK_NS);
  localparam int VHOLD_CYC = ns_to_cycles(VPP_HOLD_NS, CLK_NS);
  localparam int PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_NS);
  localparam int MAX_CYC   = max2(max2(max2(SETUP_CYC, VSU_CYC), max2(PULSE_CYC, VHOLD_CYC)),
                                  max2(HOLD_CYC, VFY_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  prog_state_e      state;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, check_fail_evt, verify_evt;
  logic             illegal, match;
  logic             res_pass, res_fail, res_rej;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr <= '0;
      req_data <= '0;
    end else if (accept) begin
      req_addr <= addr_in;
      req_data <= data_in;
    end
  end

  eprom_prog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  eprom_prog_guard #(.DATA_W(DATA_W)) u_guard (
    .rd_byte  (rd_data),
    .req_byte (req_data),
    .illegal  (illegal),
    .match    (match)
  );

  eprom_prog_fsm #(
    .CNT_W     (CNT_W),
    .VFY_CYC   (VFY_CYC),
    .SETUP_CYC (SETUP_CYC),
    .VSU_CYC   (VSU_CYC),
    .PULSE_CYC (PULSE_CYC),
    .VHOLD_CYC (VHOLD_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .tmr_zero       (tmr_zero),
    .illegal        (illegal),
    .match          (match),
    .state          (state),
    .tmr_load       (tmr_load),
    .tmr_val        (tmr_val),
    .accept         (accept),
    .check_fail_evt (check_fail_evt),
    .verify_evt     (verify_evt),
    .res_pass       (res_pass),
    .res_fail       (res_fail),
    .res_rej        (res_rej)
  );

  // Pin levels decoded from the state register.
  assign prog_addr = req_addr;
  assign prog_data = req_data;
  assign busy      = (state != ST_IDLE);
  assign verify_en = (state == ST_CHECK) || (state == ST_VERIFY);
  assign pgm_en    = (state == ST_SETUP) || (state == ST_VPP_ON) || (state == ST_PULSE) ||
                     (state == ST_VPP_HOLD) || (state == ST_RELEASE);
  assign vpp_en    = (state == ST_VPP_ON) || (state == ST_PULSE) || (state == ST_VPP_HOLD);
  assign prog_n    = (state != ST_PULSE);
  assign done      = (state == ST_DONE);
  assign pass      = done && res_pass;
  assign fail      = done && res_fail;
  assign reject    = done && res_rej;

endmodule

// File: rtl/eprom_prog_chk.sv
module eprom_prog_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              check_fail_evt,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DATA_W-1:0] prog_data,
  input logic              pgm_en,
  input logic              vpp_en,
  input logic              prog_n,
  input logic              verify_en,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic              reject
);

  p_strobe_under_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (vpp_en && pgm_en));

  p_supply_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_en |-> pgm_en);

  p_strobe_fall_after_supply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_n) |-> $past(vpp_en));

  p_enable_outlives_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vpp_en) |-> pgm_en);

  p_no_drive_during_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    verify_en |-> !pgm_en);

  p_request_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(prog_addr) && $stable(prog_data)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({pass, fail, reject}) == 1));

  p_no_result_outside_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(pass || fail || reject));

  p_precheck_rejects_r3: assert property (@(posedge clk) disable iff (!rst_n)
    check_fail_evt |=> (done && reject && !vpp_en));

endmodule

bind eprom_byte_prog eprom_prog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .check_fail_evt (check_fail_evt),
  .prog_addr      (prog_addr),
  .prog_data      (prog_data),
  .pgm_en         (pgm_en),
  .vpp_en         (vpp_en),
  .prog_n         (prog_n),
  .verify_en      (verify_en),
  .busy           (busy),
  .done           (done),
  .pass           (pass),
  .fail           (fail),
  .reject         (reject)
);

// File: tb/eprom_byte_prog_test.sv
`timescale 1ns/1ps
module eprom_byte_prog_test;

  localparam int P_CLK   = 250;
  localparam int P_OSC   = 250;
  localparam int P_EDGE  = 48;
  localparam int P_VSU   = 10000;
  localparam int P_VHOLD = 7600;
  localparam int P_PULSE = 12500;

  // Bench's own rounding: whole part plus one if any remainder.
  function automatic int cyc(input int t_ns);
    int w;
    w = t_ns / P_CLK;
    if (t_ns % P_CLK != 0) w = w + 1;
    if (w == 0) w = 1;
    return w;
  endfunction

  localparam int L_EDGE = (P_EDGE * P_OSC) / P_CLK + (((P_EDGE * P_OSC) % P_CLK) != 0 ? 1 : 0);

  int b1, b2, b3, b4, b5, b6, b7;

  logic clk = 0, rst_n = 0, start = 0;
  logic [11:0] addr_in = '0;
  logic [7:0]  data_in = '0, rd_data = 8'hFF;
  logic [11:0] prog_addr;
  logic [7:0]  prog_data;
  logic pgm_en, vpp_en, prog_n, verify_en, busy, done, pass, fail, reject;

  always #2 clk = ~clk;

  eprom_byte_prog #(
    .CLK_NS(P_CLK), .OSC_NS(P_OSC), .EDGE_OSC(P_EDGE),
    .VPP_SETUP_NS(P_VSU), .VPP_HOLD_NS(P_VHOLD), .PULSE_NS(P_PULSE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in), .data_in(data_in),
    .rd_data(rd_data), .prog_addr(prog_addr), .prog_data(prog_data), .pgm_en(pgm_en),
    .vpp_en(vpp_en), .prog_n(prog_n), .verify_en(verify_en), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .reject(reject)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Device model: cells start erased; a strobe under supply clears bits.
  logic [7:0] mem [0:4095];
  logic [11:0] stuck_addr = 12'h000;
  logic [7:0]  stuck_bits = 8'h00;
  int pulses = 0, lowcnt = 0, dones = 0;
  logic seen_pass, seen_fail, seen_rej;

  initial for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;

  always @(negedge clk) begin
    if (!prog_n && vpp_en && pgm_en)
      mem[prog_addr] = mem[prog_addr] & (prog_data | ((prog_addr == stuck_addr) ? stuck_bits : 8'h00));
    rd_data = mem[prog_addr];
    if (!prog_n) lowcnt++;
    else if (lowcnt != 0) begin
      chk("R10", "strobe low width", lowcnt, cyc(P_PULSE));
      pulses++;
      lowcnt = 0;
    end
    if (done) begin
      dones++;
      seen_pass = pass; seen_fail = fail; seen_rej = reject;
    end
  end

  // Behavioural reference: elapsed-cycle count against interval boundaries.
  bit m_active = 0;
  int t = 0, m_end = 0;
  logic [11:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  bit m_pass, m_rej;

  always @(posedge clk) begin
    if (!rst_n) m_active = 0;
    else if (!m_active) begin
      if (start) begin
        m_active = 1; t = 0; m_end = b7; m_rej = 0; m_pass = 0;
        m_addr = addr_in; m_data = data_in;
      end
    end else if (t == m_end) m_active = 0;
    else begin
      if (t == b1 - 1 && ((m_data & ~mem[m_addr]) != 8'h00)) begin m_rej = 1; m_end = b1; end
      if (t == b7 - 1) m_pass = (mem[m_addr] == m_data);
      t++;
    end
  end

  always @(negedge clk) begin
    bit dn, ve, pe, vp, pl;
    dn = m_active && (t == m_end);
    ve = m_active && !dn && ((t < b1) || (t >= b6 && t < b7));
    pe = m_active && !dn && (t >= b1 && t < b6);
    vp = m_active && !dn && (t >= b2 && t < b5);
    pl = m_active && !dn && (t >= b3 && t < b4);
    chk("R2", "busy", busy, m_active);
    chk("R2", "prog_addr", prog_addr, m_addr);
    chk("R2", "prog_data", prog_data, m_data);
    chk("R8", "verify_en", verify_en, ve);
    chk("R4 R7", "pgm_en", pgm_en, pe);
    chk("R5", "vpp_en", vpp_en, vp);
    chk("R6", "prog_n", prog_n, !pl);
    chk("R9", "done", done, dn);
    chk("R8", "pass", pass, dn && !m_rej && m_pass);
    chk("R8", "fail", fail, dn && !m_rej && !m_pass);
    chk("R3", "reject", reject, dn && m_rej);
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 60000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic go(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); start = 1; addr_in = a; data_in = d;
    @(negedge clk); start = 0;
    while (m_active) @(negedge clk);
  endtask

  initial begin
    int p0, d0;
    b1 = L_EDGE; b2 = b1 + L_EDGE; b3 = b2 + cyc(P_VSU); b4 = b3 + cyc(P_PULSE);
    b5 = b4 + cyc(P_VHOLD); b6 = b5 + L_EDGE; b7 = b6 + L_EDGE;
    repeat (4) @(negedge clk);
    chk("R1", "idle during reset", {busy, pgm_en, vpp_en, prog_n, verify_en, done, pass, fail, reject}, 9'b000100000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "idle after reset", {busy, pgm_en, vpp_en, prog_n, verify_en, done}, 6'b000100);
    chk("R1", "addr/data after reset", {prog_addr, prog_data}, 20'h0);

    go(12'h123, 8'hA5);
    chk("R8", "cell after first write", mem[12'h123], 8'hA5);
    chk("R8", "first write passes", {seen_pass, seen_fail, seen_rej}, 3'b100);

    go(12'h123, 8'h25);
    chk("R8", "clearing more bits passes", {seen_pass, seen_fail, seen_rej}, 3'b100);

    p0 = pulses;
    go(12'h123, 8'hA7);
    chk("R3", "0-to-1 request rejected", {seen_pass, seen_fail, seen_rej}, 3'b001);
    chk("R3", "no strobe on reject", pulses, p0);
    chk("R3", "cell untouched on reject", mem[12'h123], 8'h25);

    stuck_addr = 12'hFFF; stuck_bits = 8'h01;
    go(12'hFFF, 8'h00);
    chk("R8", "stuck bit gives fail", {seen_pass, seen_fail, seen_rej}, 3'b010);
    chk("R8", "stuck cell content", mem[12'hFFF], 8'h01);

    // Start pulsed mid-sequence must do nothing.
    @(negedge clk); start = 1; addr_in = 12'h000; data_in = 8'h3C;
    @(negedge clk); start = 0;
    repeat (b3 + 3) @(negedge clk);
    start = 1; addr_in = 12'h555; data_in = 8'h00;
    @(negedge clk); start = 0;
    while (m_active) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R2", "ignored start left cell erased", mem[12'h555], 8'hFF);
    chk("R2", "ignored start did not relaunch", busy, 0);
    chk("R8", "cell written by first start", mem[12'h000], 8'h3C);

    // Start held across completion: accepted again once idle.
    d0 = dones;
    @(negedge clk); start = 1; addr_in = 12'h7A0; data_in = 8'h81;
    repeat (b7 + 4) @(negedge clk);
    start = 0;
    while (m_active) @(negedge clk);
    chk("R9", "two completions for held start", dones - d0, 2);
    chk("R8", "repeat write passes", {seen_pass, seen_fail, seen_rej}, 3'b100);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule